// File: doc/BRIEF.md
# Multi-Lane Serial ADC Word Aligner

This block turns the bit-serial outputs of one eight-channel, 12-bit converter back into parallel samples. Each lane carries one channel. The converter sends two bits per bit-clock period, one on the rising edge and one on the falling edge. That gives twelve bits in each frame of a slower frame clock. The double-rate capture is modelled behaviourally: the block's own clock runs at the bit-pair rate, and each lane presents its rising-edge bit and its falling-edge bit as two inputs in the same cycle. The frame clock arrives as a level, and the block detects its rising edges itself.

Software or a sequencer raises a training request and has the converter emit two test words. The first is an alternating word, which confirms that bits are being captured cleanly. The second has six ones followed by six zeros, which marks where a word begins. Each lane runs its own small state machine. The machine keeps the last 24 received bits, tests all twelve candidate bit offsets against the boundary word at every frame, and locks once the same offset wins several frames in a row. When the request drops, locked lanes start running. When every lane is running, the block raises its aligned flag and produces one sample per lane per frame, with a one-cycle valid strobe.

Top module: `adc_lane_deser`

## Requirements
- R1: After reset, `aligned`, `sample_valid` and every bit of `lane_locked` are 0.
- R2: A lane in sync search moves to boundary search only at a frame event. A frame event is the cycle in which a rising edge of `frame_clk` is first seen. The lane moves when the 12 most recent bits, MSB first, are 101010101010 or 010101010101. A lane's state never changes between frame events except on a retrain.
- R3: A lane in boundary search locks after the word 111111000000 has been found at the same bit offset on LOCK_FRAMES (4) consecutive frame events. It never locks with fewer. `lane_locked[i]` is 1 while lane i is locked or running.
- R4: If the boundary word is missing at any frame event during boundary search, the streak restarts. A lane that sees the boundary word only on every other frame never locks.
- R5: A locked lane stays locked while `train` is high. It starts running at the first frame event with `train` low. `aligned` is 1 exactly when every lane is running.
- R6: `sample_valid` is high for exactly one cycle: the cycle after the clock edge that samples a frame event, and only when `aligned` holds.
- R7: With valid high, lane i's sample sits at `samples[12i+11:12i]`. It is the most recent complete 12-bit word of that lane at its locked offset. Within a cycle the rising-edge bit comes before the falling-edge bit, and the first bit is the MSB. Each lane has its own offset, anywhere from 0 to 11 bits of skew.
- R8: A rising edge on `train` sends every lane back to sync search on the next clock edge. `aligned` and `lane_locked` drop, and no valid pulse is produced on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-pair clock, six cycles per frame |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_clk | input | 1 | Frame clock level; its rising edge marks a frame event |
| train | input | 1 | Training request; a rising edge restarts alignment |
| lane_rise | input | LANES | Per-lane bit captured on the data-clock rising edge |
| lane_fall | input | LANES | Per-lane bit captured on the data-clock falling edge |
| samples | output | LANES*WORD | Aligned samples, lane i in bits [WORD*i +: WORD] |
| sample_valid | output | 1 | One-cycle strobe per frame while aligned |
| aligned | output | 1 | All lanes are in the running state |
| lane_locked | output | LANES | Lane has locked its word offset (locked or running) |

## Verification
The bench builds the block with its default parameters: eight lanes, 12-bit words and a four-frame lock streak. At these values every one of the twelve offsets a lane can be skewed by is reachable. The bench forces the extreme skews of 0 and 11 bits on two lanes and draws the others at random. A lock streak of four is short enough that the bench can check both sides of the threshold: no lane is locked after at most two matching frames, and all lanes are locked after seven. A single lane fed the boundary word only on every other frame shows that an interrupted streak never locks, and that one lagging lane keeps the aligned flag low.

// File: rtl/adc_deser_pkg.sv
package adc_deser_pkg;

  typedef enum logic [1:0] {
    LS_SYNC   = 2'd0,
    LS_DESKEW = 2'd1,
    LS_LOCKED = 2'd2,
    LS_RUN    = 2'd3
  } lane_state_e;

  localparam int DEF_LANES       = 8;
  localparam int DEF_WORD        = 12;
  localparam int DEF_LOCK_FRAMES = 4;

endpackage

// File: rtl/adc_frame_tracker.sv
module adc_frame_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_clk,
  input  logic train,
  output logic frame_evt,
  output logic retrain
);

  logic fclk_q;
  logic train_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fclk_q  <= 1'b0;
      train_q <= 1'b0;
    end else begin
      fclk_q  <= frame_clk;
      train_q <= train;
    end
  end

  assign frame_evt = frame_clk & ~fclk_q;
  assign retrain   = train & ~train_q;

  AST_FRAME_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_evt |=> !frame_evt); // R6

  AST_RETRAIN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    retrain |=> !retrain); // R8

endmodule

// File: rtl/adc_lane_aligner.sv
module adc_lane_aligner
  import adc_deser_pkg::*;
#(
  parameter int WORD        = DEF_WORD,
  parameter int LOCK_FRAMES = DEF_LOCK_FRAMES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_rise,
  input  logic            bit_fall,
  input  logic            frame_evt,
  input  logic            retrain,
  input  logic            train_lvl,
  output logic [WORD-1:0] sample,
  output logic            in_run,
  output logic            locked
);

  localparam int HIST = 2 * WORD;
  localparam int OFFW = $clog2(WORD);
  localparam int CNTW = $clog2(LOCK_FRAMES + 1);

  // alternating training word: odd bit positions set
  function automatic logic [WORD-1:0] alt_word();
    logic [WORD-1:0] p;
    for (int i = 0; i < WORD; i++) p[i] = (i % 2) == 1;
    return p;
  endfunction

  // boundary training word: upper half ones, lower half zeros
  function automatic logic [WORD-1:0] edge_word();
    logic [WORD-1:0] p;
    for (int i = 0; i < WORD; i++) p[i] = (i >= WORD / 2);
    return p;
  endfunction

  // WORD bits ending k bits before the newest one
  function automatic logic [WORD-1:0] window_at(input logic [HIST-1:0] h, input int k);
    return h[k +: WORD];
  endfunction

  localparam logic [WORD-1:0] SYNC_WORD   = alt_word();
  localparam logic [WORD-1:0] DESKEW_WORD = edge_word();

  logic [HIST-1:0] hist_q, hist_nx;
  lane_state_e     st_q, st_nx;
  logic [OFFW-1:0] off_q, off_nx;
  logic [CNTW-1:0] cnt_q, cnt_nx;
  logic [WORD-1:0] sample_q;

  logic            sync_seen;
  logic            desk_hit;
  logic [OFFW-1:0] desk_off;
  logic            same_off;
  logic [CNTW-1:0] streak_nx;
  logic            streak_done;

  // rising-edge bit is older than the falling-edge bit of the same cycle
  assign hist_nx = {hist_q[HIST-3:0], bit_rise, bit_fall};

  always_comb begin
    desk_hit = 1'b0;
    desk_off = '0;
    for (int k = WORD - 1; k >= 0; k--) begin
      if (window_at(hist_nx, k) == DESKEW_WORD) begin
        desk_hit = 1'b1;
        desk_off = OFFW'(k);
      end
    end
  end

  assign sync_seen   = (window_at(hist_nx, 0) == SYNC_WORD) ||
                       (window_at(hist_nx, 0) == ~SYNC_WORD);
  assign same_off    = (cnt_q != '0) && (desk_off == off_q);
  assign streak_nx   = same_off ? cnt_q + CNTW'(1) : CNTW'(1);
  assign streak_done = (streak_nx == CNTW'(LOCK_FRAMES));

  always_comb begin
    st_nx  = st_q;
    off_nx = off_q;
    cnt_nx = cnt_q;
    if (retrain) begin
      st_nx  = LS_SYNC;
      cnt_nx = '0;
    end else if (frame_evt) begin
      unique case (st_q)
        LS_SYNC: begin
          if (sync_seen) begin
            st_nx  = LS_DESKEW;
            cnt_nx = '0;
          end
        end
        LS_DESKEW: begin
          if (desk_hit) begin
            off_nx = desk_off;
            cnt_nx = streak_nx;
            if (streak_done) st_nx = LS_LOCKED;
          end else begin
            cnt_nx = '0;
          end
        end
        LS_LOCKED: begin
          if (!train_lvl) st_nx = LS_RUN;
        end
        LS_RUN: st_nx = LS_RUN;
        default: st_nx = LS_SYNC;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q   <= '0;
      st_q     <= LS_SYNC;
      off_q    <= '0;
      cnt_q    <= '0;
      sample_q <= '0;
    end else begin
      hist_q <= hist_nx;
      st_q   <= st_nx;
      off_q  <= off_nx;
      cnt_q  <= cnt_nx;
      if (frame_evt) sample_q <= window_at(hist_nx, int'(off_q));
    end
  end

  assign sample = sample_q;
  assign in_run = (st_q == LS_RUN);
  assign locked = (st_q == LS_LOCKED) || (st_q == LS_RUN);

  AST_RETRAIN_TO_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    retrain |=> (st_q == LS_SYNC)); // R8

  AST_STATE_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_evt && !retrain) |=> $stable(st_q)); // R2

  AST_LOCK_AFTER_STREAK: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LS_LOCKED && $past(st_q) == LS_DESKEW) |-> ($past(cnt_q) == CNTW'(LOCK_FRAMES - 1))); // R3

  AST_RUN_FROM_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LS_RUN && $past(st_q) != LS_RUN) |-> ($past(st_q) == LS_LOCKED && !$past(train_lvl))); // R5

endmodule

// File: rtl/adc_lane_deser.sv
module adc_lane_deser
  import adc_deser_pkg::*;
#(
  parameter int LANES       = DEF_LANES,
  parameter int WORD        = DEF_WORD,
  parameter int LOCK_FRAMES = DEF_LOCK_FRAMES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_clk,
  input  logic                  train,
  input  logic [LANES-1:0]      lane_rise,
  input  logic [LANES-1:0]      lane_fall,
  output logic [LANES*WORD-1:0] samples,
  output logic                  sample_valid,
  output logic                  aligned,
  output logic [LANES-1:0]      lane_locked
);

  logic             frame_evt;
  logic             retrain;
  logic [LANES-1:0] lane_run;
  logic             valid_q;

  adc_frame_tracker u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_clk (frame_clk),
    .train     (train),
    .frame_evt (frame_evt),
    .retrain   (retrain)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    adc_lane_aligner #(
      .WORD        (WORD),
      .LOCK_FRAMES (LOCK_FRAMES)
    ) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_rise  (lane_rise[g]),
      .bit_fall  (lane_fall[g]),
      .frame_evt (frame_evt),
      .retrain   (retrain),
      .train_lvl (train),
      .sample    (samples[g*WORD +: WORD]),
      .in_run    (lane_run[g]),
      .locked    (lane_locked[g])
    );
  end

  assign aligned = &lane_run;

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= frame_evt & aligned & ~retrain;
  end

  assign sample_valid = valid_q;

  AST_VALID_NEEDS_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> aligned); // R6

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid); // R6

  AST_ALIGN_ALL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    aligned |-> (&lane_locked)); // R5

  AST_RETRAIN_DROPS_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    retrain |=> (!aligned && lane_locked == '0)); // R8

endmodule

// File: tb/tb_adc_lane_deser.sv
module tb_adc_lane_deser;

  localparam int LANES = 8;
  localparam int WORD  = 12;
  localparam int CPF   = WORD / 2;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  frame_clk = 1'b0;
  logic                  train = 1'b0;
  logic [LANES-1:0]      lane_rise = '0;
  logic [LANES-1:0]      lane_fall = '0;
  logic [LANES*WORD-1:0] samples;
  logic                  sample_valid;
  logic                  aligned;
  logic [LANES-1:0]      lane_locked;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int mode = 0;
  bit chk_run = 1'b0;
  bit chk_quiet = 1'b0;
  bit done = 1'b0;
  int skew [LANES];
  logic [WORD-1:0] wmem [LANES][256];

  adc_lane_deser #(.LANES(LANES), .WORD(WORD), .LOCK_FRAMES(4)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_clk    (frame_clk),
    .train        (train),
    .lane_rise    (lane_rise),
    .lane_fall    (lane_fall),
    .samples      (samples),
    .sample_valid (sample_valid),
    .aligned      (aligned),
    .lane_locked  (lane_locked)
  );

  always #5 clk = ~clk;

  // word j of a lane under a stimulus mode
  function automatic logic [WORD-1:0] gen_word(input int lane, input int j, input int md);
    case (md)
      1: return 12'hAAA;
      2: return 12'hFC0;
      3: return WORD'($urandom);
      4: return (lane == 5 && (j % 2) == 1) ? 12'h000 : 12'hFC0;
      default: return '0;
    endcase
  endfunction

  // bit g of the lane's stream, shifted by its skew, MSB first
  function automatic logic stream_bit(input int lane, input int g);
    int i;
    logic [WORD-1:0] w;
    i = g + skew[lane];
    w = wmem[lane][(i / WORD) % 256];
    return w[WORD - 1 - (i % WORD)];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic post_checks();
    int pc;
    int m;
    int j;
    pc = cyc - 1;
    if (pc < 0) return;
    if (chk_run) begin
      if (pc % CPF == 0) begin
        check(sample_valid == 1'b1, "R6 valid at frame", int'(sample_valid), 1);
        m = pc / CPF;
        for (int l = 0; l < LANES; l++) begin
          j = (WORD * m + skew[l] - 10) / WORD;
          check(samples[l*WORD +: WORD] == wmem[l][j % 256], "R7 lane sample",
                int'(samples[l*WORD +: WORD]), int'(wmem[l][j % 256]));
        end
      end else begin
        check(sample_valid == 1'b0, "R6 valid single cycle", int'(sample_valid), 0);
      end
    end
    if (chk_quiet) check(sample_valid == 1'b0, "R5 no valid while unaligned", int'(sample_valid), 0);
  endtask

  task automatic tick();
    int p;
    int m;
    @(negedge clk);
    post_checks();
    p = cyc % CPF;
    if (p == 0) begin
      m = cyc / CPF;
      for (int l = 0; l < LANES; l++) wmem[l][(m + 1) % 256] = gen_word(l, m + 1, mode);
    end
    frame_clk = (p < CPF / 2);
    for (int l = 0; l < LANES; l++) begin
      lane_rise[l] = stream_bit(l, 2 * cyc);
      lane_fall[l] = stream_bit(l, 2 * cyc + 1);
    end
    cyc++;
  endtask

  task automatic frames(input int n);
    repeat (n * CPF) tick();
  endtask

  task automatic settle();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int l = 0; l < LANES; l++) begin
      skew[l] = $urandom % WORD;
      for (int k = 0; k < 256; k++) wmem[l][k] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(aligned == 1'b0, "R1 aligned after reset", int'(aligned), 0);
    check(sample_valid == 1'b0, "R1 valid after reset", int'(sample_valid), 0);
    check(lane_locked == '0, "R1 locked after reset", int'(lane_locked), 0);
    rst_n = 1'b1;
    mode = 0;
    frames(2);
    settle();
    check(lane_locked == '0, "R2 no lock without training", int'(lane_locked), 0);

    // training with lane 5 seeing the boundary word every other frame
    train = 1'b1;
    mode = 1;
    frames(3);
    mode = 4;
    frames(9);
    settle();
    check(lane_locked == 8'hDF, "R4 broken streak lane stays unlocked", int'(lane_locked), 8'hDF);
    check(aligned == 1'b0, "R5 aligned low while training", int'(aligned), 0);
    train = 1'b0;
    chk_quiet = 1'b1;
    frames(4);
    settle();
    check(aligned == 1'b0, "R5 one lagging lane keeps aligned low", int'(aligned), 0);
    check(lane_locked == 8'hDF, "R5 other lanes run", int'(lane_locked), 8'hDF);
    chk_quiet = 1'b0;

    // clean training with extreme skews on lanes 0 and 1
    for (int l = 0; l < LANES; l++) skew[l] = $urandom % WORD;
    skew[0] = 0;
    skew[1] = 11;
    train = 1'b1;
    mode = 1;
    frames(3);
    mode = 2;
    frames(3);
    settle();
    check(lane_locked == '0, "R3 no lock before streak", int'(lane_locked), 0);
    frames(6);
    settle();
    check(lane_locked == 8'hFF, "R3 all lanes locked", int'(lane_locked), 8'hFF);
    check(aligned == 1'b0, "R5 locked lanes wait for train low", int'(aligned), 0);
    train = 1'b0;
    mode = 3;
    frames(1);
    settle();
    check(aligned == 1'b1, "R5 aligned after train low", int'(aligned), 1);
    chk_run = 1'b1;
    frames(30);
    chk_run = 1'b0;

    // retrain while running
    train = 1'b1;
    tick();
    settle();
    check(aligned == 1'b0, "R8 aligned drops on retrain", int'(aligned), 0);
    check(lane_locked == '0, "R8 locks clear on retrain", int'(lane_locked), 0);
    check(sample_valid == 1'b0, "R8 no valid on retrain edge", int'(sample_valid), 0);

    // realign with fresh random skews and run again
    for (int l = 0; l < LANES; l++) skew[l] = $urandom % WORD;
    mode = 1;
    frames(3);
    mode = 2;
    frames(9);
    train = 1'b0;
    mode = 3;
    frames(1);
    settle();
    check(aligned == 1'b1, "R7 realigned after new skews", int'(aligned), 1);
    chk_run = 1'b1;
    frames(20);
    chk_run = 1'b0;
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R6 watchdog actual=timeout expected=finish");
      finish_run();
    end
  end

endmodule